// File: doc/BRIEF.md
# Raster-Stream Diffusion Update Stage

This block performs one iteration of an edge-preserving smoothing step on a stream of 256 by 256 pixel frames that arrive in raster order. Each accepted pixel carries three tensor weights: a horizontal weight, a cross weight and a vertical weight. The stage forms the difference to the left neighbour and the difference to the neighbour one line above, using a one-sample register and a one-line buffer. It weights those differences into two flux terms, adds the flux terms together, scales the sum by a step size and subtracts the result from the pixel. The updated pixel is then limited to a lower and an upper bound.

All samples are 16-bit signed fixed point with FRAC fractional bits (12 by default). Input and output are valid/ready streams. A beat moves when valid and ready are both high at a rising clock edge. The pipeline advances as a single unit. When the output holds a valid result and the consumer does not assert ready, every stage freezes, the output data stays stable, and input ready drops. Cycles in which no input beat is accepted do not advance the raster position. The step size and the bounds are plain inputs. They must stay constant while results are in flight.

Top module: `dif_update_stage`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. The raster position is column 0 of row 0.
- R2: The horizontal difference dx is the accepted pixel minus the previously accepted pixel, saturated to 16 bits. In column 0 of each line it is 0.
- R3: The vertical difference dy is the accepted pixel minus the pixel accepted 256 beats earlier, saturated to 16 bits. In row 0 it is 0. The row count wraps after 256 lines, so row 0 starts each frame.
- R4: A weighted product m(a,b) is (a*b + 2^(FRAC-1)) arithmetically shifted right by FRAC and then saturated to [-32768, 32767]. The flux terms are fx = sat(m(g11,dx) + m(g12,dy)) and fy = sat(m(g12,dx) + m(g22,dy)).
- R5: The unclamped result is sat(p - m(dt, sat(fx + fy))), where p is the accepted pixel.
- R6: The output is `lim_lo` if the unclamped result is below `lim_lo`. Otherwise it is `lim_hi` if the result is above `lim_hi`. Otherwise it is the result itself. All comparisons are signed.
- R7: With `out_ready` held high, a pixel accepted at one clock edge appears with `out_valid` high after exactly 6 rising edges, counting the accepting edge. Results leave in acceptance order.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_pix` and `out_valid` hold. While `out_valid` is 0, `in_ready` is 1.
- R9: Cycles without an accepted input beat leave the raster position and both delay taps unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can take an input beat |
| in_pix | input | 16 | Pixel, signed fixed point |
| in_g11 | input | 16 | Horizontal weight |
| in_g12 | input | 16 | Cross weight |
| in_g22 | input | 16 | Vertical weight |
| dt | input | 16 | Step size, signed fixed point |
| lim_lo | input | 16 | Lower output bound |
| lim_hi | input | 16 | Upper output bound |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_pix | output | 16 | Updated, clamped pixel |

## Verification
A full frame and more is streamed at one beat per clock with moderate random pixels and weights and tight bounds. This run separates the column-0 and row-0 zeroing, the one-line tap, the frame wrap and the clamp from the plain arithmetic. A second run gates both valid and ready at random. Any result that depends on clock cycles rather than accepted beats then diverges, and any failure to freeze under back-pressure shows up. A final directed run drives alternating full-scale pixels with full-scale weights and step size, so the rounding and every saturation point decide the outcome.

// File: rtl/dif_pkg.sv
package dif_pkg;

  // Clamp a wide signed value to the signed range of w bits.
  function automatic logic signed [63:0] sat_w(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Round half up, then shift right arithmetically by f bits.
  function automatic logic signed [63:0] rnd_shr(input logic signed [63:0] v, input int f);
    if (f == 0) return v;
    return (v + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

endpackage

// File: rtl/dif_delay.sv
module dif_delay #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic signed [W-1:0] stg [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else if (en) begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dif_mul.sv
module dif_mul #(
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);
  import dif_pkg::*;

  logic signed [2*DW-1:0] prod;
  logic signed [63:0]     wide;

  assign prod = a * b;
  assign wide = 64'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else if (en) y <= DW'(sat_w(rnd_shr(wide, FRAC), DW));
  end
endmodule

// File: rtl/dif_taps.sv
module dif_taps #(
  parameter int DW   = 16,
  parameter int LINE = 256,
  parameter int ROWS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic signed [DW-1:0] pix,
  output logic signed [DW-1:0] dx,
  output logic signed [DW-1:0] dy
);
  import dif_pkg::*;

  localparam int CW = (LINE > 1) ? $clog2(LINE) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CW-1:0]       col;
  logic [RW-1:0]       row;
  logic signed [DW-1:0] left;
  logic signed [DW-1:0] line_mem [LINE];
  logic signed [DW-1:0] up;

  assign up = line_mem[col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      row  <= '0;
      left <= '0;
    end else if (take) begin
      left <= pix;
      if (col == CW'(LINE - 1)) begin
        col <= '0;
        row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) line_mem[col] <= pix;
  end

  always_comb begin
    dx = (col == '0) ? '0 : DW'(sat_w(64'(pix) - 64'(left), DW));
    dy = (row == '0) ? '0 : DW'(sat_w(64'(pix) - 64'(up), DW));
  end
endmodule

// File: rtl/dif_update_stage.sv
module dif_update_stage #(
  parameter int DW   = 16,
  parameter int FRAC = 12,
  parameter int LINE = 256,
  parameter int ROWS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_pix,
  input  logic signed [DW-1:0] in_g11,
  input  logic signed [DW-1:0] in_g12,
  input  logic signed [DW-1:0] in_g22,
  input  logic signed [DW-1:0] dt,
  input  logic signed [DW-1:0] lim_lo,
  input  logic signed [DW-1:0] lim_hi,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_pix
);
  import dif_pkg::*;

  localparam int LAT  = 6;
  localparam int NMUL = 4;
  localparam int BYP  = LAT - 2;

  logic           adv;
  logic           take;
  logic [LAT:1]   vld;

  assign adv       = !vld[LAT] || out_ready;
  assign in_ready  = adv;
  assign take      = in_valid && adv;
  assign out_valid = vld[LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (adv) vld <= {vld[LAT-1:1], take};
  end

  // Stage 0: raster taps and differences
  logic signed [DW-1:0] dx0, dy0;

  dif_taps #(.DW(DW), .LINE(LINE), .ROWS(ROWS)) u_taps (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .pix  (in_pix),
    .dx   (dx0),
    .dy   (dy0)
  );

  // Stage 1: capture operands
  logic signed [DW-1:0] p1, w11_1, w12_1, w22_1, dx1, dy1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0; w11_1 <= '0; w12_1 <= '0; w22_1 <= '0; dx1 <= '0; dy1 <= '0;
    end else if (adv) begin
      p1 <= in_pix; w11_1 <= in_g11; w12_1 <= in_g12; w22_1 <= in_g22;
      dx1 <= dx0; dy1 <= dy0;
    end
  end

  // Stage 2: four weighted products
  logic signed [DW-1:0] ma [NMUL];
  logic signed [DW-1:0] mb [NMUL];
  logic signed [DW-1:0] mp [NMUL];

  assign ma[0] = w11_1; assign mb[0] = dx1;
  assign ma[1] = w12_1; assign mb[1] = dy1;
  assign ma[2] = w12_1; assign mb[2] = dx1;
  assign ma[3] = w22_1; assign mb[3] = dy1;

  generate
    for (genvar k = 0; k < NMUL; k++) begin : g_prod
      dif_mul #(.DW(DW), .FRAC(FRAC)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (adv),
        .a    (ma[k]),
        .b    (mb[k]),
        .y    (mp[k])
      );
    end
  endgenerate

  // Stage 3: flux terms; stage 4: their sum
  logic signed [DW-1:0] fx3, fy3, s4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx3 <= '0; fy3 <= '0; s4 <= '0;
    end else if (adv) begin
      fx3 <= DW'(sat_w(64'(mp[0]) + 64'(mp[1]), DW));
      fy3 <= DW'(sat_w(64'(mp[2]) + 64'(mp[3]), DW));
      s4  <= DW'(sat_w(64'(fx3) + 64'(fy3), DW));
    end
  end

  // Stage 5: step scaling, pixel bypass aligned to it
  logic signed [DW-1:0] u5, p5;

  dif_mul #(.DW(DW), .FRAC(FRAC)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (adv),
    .a    (dt),
    .b    (s4),
    .y    (u5)
  );

  dif_delay #(.W(DW), .DEPTH(BYP)) u_pbyp (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (adv),
    .d    (p1),
    .q    (p5)
  );

  // Stage 6: update and clamp
  logic signed [DW-1:0] upd;
  assign upd = DW'(sat_w(64'(p5) - 64'(u5), DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_pix <= '0;
    else if (adv) begin
      if (upd < lim_lo)      out_pix <= lim_lo;
      else if (upd > lim_hi) out_pix <= lim_hi;
      else                   out_pix <= upd;
    end
  end
endmodule

// File: rtl/dif_update_stage_sva.sv
module dif_update_stage_sva #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_ready,
  input logic signed [DW-1:0] lim_lo,
  input logic signed [DW-1:0] lim_hi,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_pix
);
  p_empty_after_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_hold_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  p_block_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_free_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_within_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (lim_lo <= lim_hi) |-> (out_pix >= lim_lo) && (out_pix <= lim_hi));
endmodule

bind dif_update_stage dif_update_stage_sva #(.DW(DW)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .lim_lo   (lim_lo),
  .lim_hi   (lim_hi),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_pix  (out_pix)
);

// File: tb/dif_update_stage_test.sv
module dif_update_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] in_pix = '0, in_g11 = '0, in_g12 = '0, in_g22 = '0;
  logic signed [15:0] dt = '0, lim_lo = '0, lim_hi = '0;
  logic signed [15:0] out_pix;

  always #2 clk = ~clk;

  dif_update_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_g11(in_g11), .in_g12(in_g12), .in_g22(in_g22),
    .dt(dt), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int checks = 0, fails = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];
  int hist[256];
  int left_v = 0, kbeat = 0, phase = 0;
  int first_in = -1, first_out = -1;
  bit stall_seen = 0;
  logic signed [15:0] stall_val = '0;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int mr(int a, int b);
    longint p;
    p = longint'(a) * longint'(b);
    return sat16((p + 2048) >>> 12);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Model of R2..R6 for one accepted beat
  task automatic model(int p, int g11, int g12, int g22);
    int col, row, up, dxv, dyv, fx, fy, s, u, d, y;
    string tg;
    col = kbeat % 256;
    row = (kbeat / 256) % 256;
    up  = hist[col];
    dxv = (col == 0) ? 0 : sat16(longint'(p) - left_v);
    dyv = (row == 0) ? 0 : sat16(longint'(p) - up);
    fx  = sat16(longint'(mr(g11, dxv)) + mr(g12, dyv));
    fy  = sat16(longint'(mr(g12, dxv)) + mr(g22, dyv));
    s   = sat16(longint'(fx) + fy);
    u   = mr(int'(dt), s);
    d   = sat16(longint'(p) - u);
    y   = d;
    tg  = "R5";
    if (d < int'(lim_lo)) begin y = int'(lim_lo); tg = "R6"; end
    else if (d > int'(lim_hi)) begin y = int'(lim_hi); tg = "R6"; end
    if (phase == 3) tg = "R4";
    else if (phase == 2) tg = "R9";
    else if (col == 0) tg = "R2";
    else if (row == 0 || (kbeat >= 65536 && kbeat < 65536 + 256)) tg = "R3";
    hist[col] = p;
    left_v = p;
    kbeat++;
    exp_q.push_back(y);
    tag_q.push_back(tg);
  endtask

  // One cycle: inputs set at negedge, handshakes resolved at the next posedge
  task automatic cycle(bit iv, bit ordy, int p, int g11, int g12, int g22);
    @(negedge clk);
    if (stall_seen) begin
      check(out_valid && out_pix == stall_val, "R8 hold", int'(out_pix), int'(stall_val));
      stall_seen = 0;
    end
    in_valid = iv; out_ready = ordy;
    in_pix = 16'(p); in_g11 = 16'(g11); in_g12 = 16'(g12); in_g22 = 16'(g22);
    #1;
    if (out_valid && first_out < 0) first_out = cyc;
    if (out_valid && !out_ready) begin
      check(!in_ready, "R8 in_ready", int'(in_ready), 0);
      stall_seen = 1;
      stall_val = out_pix;
    end
    if (out_valid && out_ready) begin
      int e;
      string t;
      if (exp_q.size() == 0) check(0, "R7 extra output", int'(out_pix), 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(out_pix) == e, t, int'(out_pix), e);
      end
    end
    if (in_valid && in_ready) begin
      if (first_in < 0) first_in = cyc;
      model(p, g11, g12, g22);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) cycle(0, 1, 0, 0, 0, 0);
    check(exp_q.size() == 0, "R7 drain", exp_q.size(), 0);
  endtask

  function automatic int rnd_range(int lim);
    return int'($urandom % (2 * lim + 1)) - lim;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // Phase 1: full rate, over one frame, tight bounds
    phase = 1; dt = 16'sh0800; lim_lo = -16'sd3000; lim_hi = 16'sd3000;
    for (int i = 0; i < 65536 + 400; i++)
      cycle(1, 1, rnd_range(4096), rnd_range(4096), rnd_range(4096), rnd_range(4096));
    check(first_out - first_in == 6, "R7 latency", first_out - first_in, 6);
    drain();

    // Phase 2: random gaps on both sides
    phase = 2; dt = 16'sh1000; lim_lo = -16'sd32768; lim_hi = 16'sd32767;
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 10) < 7, ($urandom % 10) < 6,
            rnd_range(8000), rnd_range(6000), rnd_range(6000), rnd_range(6000));
    drain();

    // Phase 3: full-scale saturation corners
    phase = 3; dt = 16'sh7fff;
    for (int i = 0; i < 600; i++) begin
      int p;
      p = (i % 2 == 0) ? 32767 : -32768;
      if (i % 7 == 3) p = 0;
      cycle(1, 1, p, 32767, (i % 3 == 0) ? -32768 : 32767, 32767);
    end
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule